// File: doc/BRIEF.md
# Timer Compare Channel

This block is one compare channel that watches a free-running timer. It holds a programmable compare value and raises an event when the timer count reaches that value. A three-bit mode input decides what the event does. It can raise an interrupt only, or raise an interrupt and invert an output latch, or raise an interrupt only on the first match in each timer period. The timer, the pin direction logic and the interrupt controller are outside the block. The block receives the timer count and a wrap strobe, and it drives the latch value and a one-cycle interrupt request.

A match counts only on the cycle where the count first becomes equal to the compare value. If the timer is prescaled and holds an equal count for several cycles, the channel still sees a single event. Software can write the output latch at any time, and such a write overrides a compare toggle that occurs in the same cycle.

The once-per-period mode uses a two-state machine. In ARMED, a match fires and the transition FIRE leads to BLOCKED. In BLOCKED, matches are suppressed. The transition REARM leads back to ARMED and is taken on a timer wrap or on any change of the mode input. Both results are registered, so `irq` and `out_latch` change one clock after the inputs that cause them.

Top module: `cmp_channel`

## Requirements
- R1: After reset, `out_latch` is 0, `irq` is 0 and the once-per-period machine is ARMED.
- R2: A match is detected only on the cycle where `tmr_count` becomes equal to the compare register after being unequal. An equal count that is held for further cycles gives no further event. `irq` is a one-cycle pulse that appears on the clock after the matching count.
- R3: Mode 3'b000 disables the channel. The codes 3'b001, 3'b010, 3'b011 and 3'b111 also act as disabled. In a disabled mode a match raises no `irq` and leaves `out_latch` unchanged.
- R4: Mode 3'b100 (interrupt-only) pulses `irq` on every match and never changes `out_latch`.
- R5: Mode 3'b101 (toggle) pulses `irq` and inverts `out_latch` on every match, including several matches within one timer period.
- R6: In mode 3'b101, `tmr_ovf` leaves `out_latch` unchanged and does not enable or disable later matches.
- R7: Mode 3'b110 (once-per-period) pulses `irq` only on the first match after the channel is armed. Later matches raise nothing until `tmr_ovf` rearms the channel.
- R8: In mode 3'b110, loading a compare value above the current count after the first match does not produce an event before the next `tmr_ovf`.
- R9: In mode 3'b110, matches never change `out_latch`.
- R10: When `latch_we` is high, `out_latch` takes `latch_wdata` on the next clock. This write wins over a compare toggle in the same cycle, and that cycle's `irq` is still raised.
- R11: Any change of `mode` rearms the once-per-period machine, so a match in that same cycle under mode 3'b110 fires.
- R12: `cmp_wdata` is loaded into the compare register on a clock where `cmp_we` is high, and the new value is compared from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_count | input | CNT_W | Current timer count |
| tmr_ovf | input | 1 | Timer wrap strobe, one cycle |
| cmp_wdata | input | CNT_W | New compare value |
| cmp_we | input | 1 | Compare register write strobe |
| mode | input | 3 | Channel mode select |
| latch_wdata | input | 1 | Software value for the output latch |
| latch_we | input | 1 | Software write strobe for the output latch |
| out_latch | output | 1 | Output latch value |
| irq | output | 1 | Interrupt request pulse |

## Verification
The same compare value is approached several times in each mode, from a lower count, from a higher count and with the count held, so that the bench can separate detecting the edge of equality from detecting plain equality. Repeated matches inside one period show the difference between toggle and interrupt-only behaviour, which repeat, and once-per-period behaviour, which stays silent until a wrap or a mode change rearms it. A compare reload above the count after the first match checks that the blocking survives the reload. A latch write that coincides with a toggle uses a value the toggle would not produce, so that it can show which of the two won.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam logic [2:0] MODE_OFF    = 3'b000;
    localparam logic [2:0] MODE_IRQ    = 3'b100;
    localparam logic [2:0] MODE_TOGGLE = 3'b101;
    localparam logic [2:0] MODE_ONCE   = 3'b110;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_BLOCKED = 1'b1
    } once_st_t;
endpackage

// File: rtl/cmp_match.sv
module cmp_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_count,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cmp_we,
    output logic             hit
);
    logic [CNT_W-1:0] cmp_q;
    logic             eq;
    logic             eq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            eq_q  <= 1'b0;
        end else begin
            if (cmp_we) cmp_q <= cmp_wdata;
            eq_q <= eq;
        end
    end

    always_comb begin
        eq  = (tmr_count == cmp_q);
        hit = eq && !eq_q;
    end

    // R2: a hit is never followed directly by another hit
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/cmp_once_fsm.sv
module cmp_once_fsm
    import cmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic once_en,
    input  logic mode_chg,
    input  logic ovf,
    input  logic hit,
    output logic fire
);
    once_st_t state, state_nx;
    logic     armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        armed    = (state == ST_ARMED) || ovf || mode_chg;
        fire     = once_en && hit && armed;
        state_nx = state;
        unique case (state)
            ST_ARMED: begin
                if (fire) state_nx = ST_BLOCKED;
            end
            ST_BLOCKED: begin
                if (fire)                 state_nx = ST_BLOCKED;
                else if (ovf || mode_chg) state_nx = ST_ARMED;
            end
            default: state_nx = ST_ARMED;
        endcase
    end

    // R7: while blocked and not rearmed, no event escapes
    a_r7_blocked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLOCKED && !ovf && !mode_chg) |-> !fire);
    // R7: a fired event leaves the machine blocked
    a_r7_fire_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state == ST_BLOCKED));
endmodule

// File: rtl/cmp_latch.sv
module cmp_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    input  logic sw_we,
    input  logic sw_data,
    output logic latch_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      latch_q <= 1'b0;
        else if (sw_we)  latch_q <= sw_data;
        else if (toggle) latch_q <= ~latch_q;
    end

    // R10: a software write always lands
    a_r10_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (latch_q == $past(sw_data)));
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
    import cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_count,
    input  logic             tmr_ovf,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cmp_we,
    input  logic [2:0]       mode,
    input  logic             latch_wdata,
    input  logic             latch_we,
    output logic             out_latch,
    output logic             irq
);
    logic [2:0] mode_q;
    logic       mode_chg;
    logic       hit;
    logic       fire_once;
    logic       once_en;
    logic       do_toggle;
    logic       irq_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            irq    <= 1'b0;
        end else begin
            mode_q <= mode;
            irq    <= irq_nx;
        end
    end

    always_comb begin
        mode_chg  = (mode != mode_q);
        once_en   = 1'b0;
        do_toggle = 1'b0;
        irq_nx    = 1'b0;
        unique case (mode)
            MODE_IRQ:    irq_nx = hit;
            MODE_TOGGLE: begin
                irq_nx    = hit;
                do_toggle = hit;
            end
            MODE_ONCE: begin
                once_en = 1'b1;
                irq_nx  = fire_once;
            end
            default: ;
        endcase
    end

    cmp_match #(.CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_count (tmr_count),
        .cmp_wdata (cmp_wdata),
        .cmp_we    (cmp_we),
        .hit       (hit)
    );

    cmp_once_fsm u_once (
        .clk      (clk),
        .rst_n    (rst_n),
        .once_en  (once_en),
        .mode_chg (mode_chg),
        .ovf      (tmr_ovf),
        .hit      (hit),
        .fire     (fire_once)
    );

    cmp_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .toggle  (do_toggle),
        .sw_we   (latch_we),
        .sw_data (latch_wdata),
        .latch_q (out_latch)
    );

    // R2: the interrupt request is a single-cycle pulse
    a_r2_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R3: disabled mode raises nothing and keeps the latch
    a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && !latch_we) |=> (!irq && $stable(out_latch)));
    // R5: a toggle-mode hit inverts the latch
    a_r5_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TOGGLE && hit && !latch_we) |=> (out_latch != $past(out_latch)));
    // R9: once-per-period mode leaves the latch alone
    a_r9_once_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ONCE && !latch_we) |=> $stable(out_latch));
endmodule

// File: tb/test_cmp_channel.sv
module test_cmp_channel;
    localparam int CNT_W  = 16;
    localparam int PERIOD = 10;

    typedef struct {
        logic  irq;
        logic  lat;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] tmr_count = '0;
    logic             tmr_ovf = 1'b0;
    logic [CNT_W-1:0] cmp_wdata = '0;
    logic             cmp_we = 1'b0;
    logic [2:0]       mode = 3'b000;
    logic             latch_wdata = 1'b0;
    logic             latch_we = 1'b0;
    logic             out_latch;
    logic             irq;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    cmp_channel #(.CNT_W(CNT_W)) i_cmp_channel (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_count   (tmr_count),
        .tmr_ovf     (tmr_ovf),
        .cmp_wdata   (cmp_wdata),
        .cmp_we      (cmp_we),
        .mode        (mode),
        .latch_wdata (latch_wdata),
        .latch_we    (latch_we),
        .out_latch   (out_latch),
        .irq         (irq)
    );

    // monitor: one expected item per clock, sampled shortly after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (irq !== e.irq || out_latch !== e.lat) begin
                n_errors++;
                $display("FAIL %s: irq=%b latch=%b expected irq=%b latch=%b",
                         e.tag, irq, out_latch, e.irq, e.lat);
            end
        end
    end

    // driver: called at a falling edge, drives one cycle of inputs
    task automatic step(input int cnt, input bit ovf, input bit e_irq,
                        input bit e_lat, input string tag);
        exp_t e;
        tmr_count = cnt[CNT_W-1:0];
        tmr_ovf   = ovf;
        e.irq = e_irq;
        e.lat = e_lat;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        cmp_we   = 1'b0;
        latch_we = 1'b0;
        tmr_ovf  = 1'b0;
    endtask

    initial begin
        #(PERIOD*5000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_checks++;
        if (irq !== 1'b0 || out_latch !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: irq=%b latch=%b expected irq=0 latch=0", irq, out_latch);
        end

        // R12: load compare value 10
        cmp_wdata = 10; cmp_we = 1'b1;
        step(0, 0, 0, 0, "R12 load");
        step(10, 0, 0, 0, "R3 mode off ignores match");
        step(11, 0, 0, 0, "R3 off idle");

        mode = 3'b100;
        step(10, 0, 1, 0, "R4 irq-only match");
        step(10, 0, 0, 0, "R2 held equal no repeat");
        step(11, 0, 0, 0, "R2 unequal");
        step(10, 0, 1, 0, "R4 second match latch untouched");

        mode = 3'b101;
        step(5, 0, 0, 0, "R5 idle");
        step(10, 0, 1, 1, "R5 first toggle");
        step(11, 0, 0, 1, "R5 hold");
        step(10, 0, 1, 0, "R5 second toggle same period");
        step(11, 1, 0, 0, "R6 overflow keeps latch");
        step(10, 0, 1, 1, "R6 events continue after overflow");
        step(0, 0, 0, 1, "R6 idle");
        latch_wdata = 1'b1; latch_we = 1'b1;
        step(10, 0, 1, 1, "R10 software write beats toggle");
        step(11, 0, 0, 1, "R10 hold");
        latch_wdata = 1'b0; latch_we = 1'b1;
        step(3, 0, 0, 0, "R10 plain write");

        mode = 3'b110;
        step(10, 0, 1, 0, "R7 first match fires");
        step(11, 0, 0, 0, "R7 idle");
        step(10, 0, 0, 0, "R7 second match blocked");
        cmp_wdata = 20; cmp_we = 1'b1;
        step(12, 0, 0, 0, "R12 reload compare");
        step(20, 0, 0, 0, "R8 reload above count stays blocked");
        step(21, 0, 0, 0, "R8 idle");
        step(0, 1, 0, 0, "R7 overflow rearms");
        step(20, 0, 1, 0, "R8 fires after overflow");
        latch_wdata = 1'b1; latch_we = 1'b1;
        step(5, 0, 0, 1, "R10 write in once mode");
        step(0, 1, 0, 1, "R9 overflow");
        step(20, 0, 1, 1, "R9 match leaves latch");
        step(21, 0, 0, 1, "R9 idle");

        mode = 3'b100;
        step(22, 0, 0, 1, "R11 leave once mode");
        mode = 3'b110;
        step(20, 0, 1, 1, "R11 mode change rearms");

        mode = 3'b111;
        step(21, 0, 0, 1, "R3 unused idle");
        step(20, 0, 0, 1, "R3 unused code acts off");

        repeat (2) @(negedge clk);
        n_checks++;
        if (q.size() != 0) begin
            n_errors++;
            $display("FAIL R2: %0d items unchecked, expected 0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule